// File: doc/BRIEF.md
# Shift-and-Select Signed Coefficient Multiplier

This block multiplies a signed input sample by a signed 16-bit coefficient. It does this without a general array multiplier. Both operands are first reduced to magnitudes. The only arithmetic on the sample is one adder that forms three times its magnitude. The coefficient magnitude is then cut into eight 2-bit slices. Each slice drives a 4:1 selector that picks zero, one, two or three times the sample magnitude.

The eight selected terms are weighted by their slice position and summed in a tree:
- four pair adders,
- then two nibble adders,
- then one final Brent-Kung parallel-prefix adder.

A control module looks at the coefficient magnitude in 2-bit, 4-bit and 8-bit groups. Whenever the upper operand of an adder would be zero, the control bypasses that adder, so the adder inputs stay quiet.

The magnitude result is negated when exactly one operand is negative. It is then registered together with a valid flag. Each new operand pair is accepted on a valid cycle, and the full-precision signed product appears one clock later. A filter or pulse-shaping datapath uses this block as its tap multiplier.

Top module: `csm_mult`

## Requirements
- R1: While reset (`rstN` low) is asserted, `outValid` is 0 and `product` is 0.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge.
- R3: After a clock edge at which `inValid` is 1, `product` equals the two's-complement product of `sample` and `coef` as they were at that edge, sign-extended to DATA_W+16 bits.
- R4: At a clock edge where `inValid` is 0, `product` keeps its value, whatever `sample` and `coef` are doing.
- R5: Every 2-bit coefficient slice value (0, 1, 2, 3) in every slice position, that is coefficients of the form v<<(2*i), gives the exact product. This covers the 3x term, which is the only one that needs an addition.
- R6: The most negative sample (-2^(DATA_W-1)) and the most negative coefficient (-32768) are multiplied exactly, including the case where both are at their extreme together.
- R7: A zero sample or a zero coefficient yields a product of exactly 0.
- R8: Coefficients whose upper slice, upper nibble or upper byte is zero, so that an adder is bypassed, still produce the exact product.
- R9: When both operands are nonzero, the product sign bit equals the XOR of the sign bits of `sample` and `coef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on `sample` and `coef` is to be multiplied |
| sample | input | DATA_W | Signed two's-complement sample |
| coef | input | 16 | Signed two's-complement coefficient |
| outValid | output | 1 | `product` holds a new result |
| product | output | DATA_W+16 | Registered signed product |

## Verification
The bench builds the block with DATA_W set to 6. This makes the sample space small enough that every one of its 64 values can be swept against each chosen coefficient. The sample sweep hits the extreme negative value and zero on every coefficient.

The coefficients tried are:
- the corner values;
- every slice value in every slice position, together with their negations;
- sparse patterns that bypass each adder layer;
- a few hundred pseudo-random values.

Because of this, every selector setting and every bypass path of the tree is exercised against an arithmetic reference.

// File: rtl/csm_pkg.sv
package csm_pkg;
  // Coefficient structure: fixed at 16 bits, cut into 2-bit slices.
  localparam int COEF_W  = 16;
  localparam int SLICE_N = COEF_W / 2;   // 2-bit slices
  localparam int PAIR_N  = SLICE_N / 2;  // nibbles, one pair adder each
  localparam int BYTE_N  = PAIR_N / 2;   // bytes, one nibble adder each

  // Strobes from control to datapath.
  typedef struct packed {
    logic              load;     // capture a new result
    logic              negate;   // result sign is negative
    logic [PAIR_N-1:0] pairAdd;  // upper slice of nibble k is nonzero
    logic [BYTE_N-1:0] nibAdd;   // upper nibble of byte b is nonzero
    logic              byteAdd;  // upper byte is nonzero
  } csmCtrl_t;
endpackage

// File: rtl/csm_bk_adder.sv
module csm_bk_adder #(
  parameter int W = 22
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);
  localparam int LV  = $clog2(W);
  localparam int NST = 2 * LV - 1;

  logic [NST:0][W-1:0]   gS;
  logic [NST-1:0][W-1:0] pS;
  logic [W-1:0]          carry;

  // pre-computation: bit generate / propagate
  assign gS[0] = opA & opB;
  assign pS[0] = opA ^ opB;

  // prefix network: LV up-sweep levels then LV-1 down-sweep levels
  for (genvar s = 0; s < NST; s++) begin : g_stage
    localparam bit UP   = (s < LV);
    localparam int DIST = UP ? (1 << s) : (1 << (2 * LV - 2 - s));
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam bit HIT = UP ? (((i + 1) % (2 * DIST)) == 0)
                              : ((((i + 1) % (2 * DIST)) == DIST) && ((i + 1) > 2 * DIST));
      if (HIT) begin : g_cell
        assign gS[s+1][i] = gS[s][i] | (pS[s][i] & gS[s][i-DIST]);
        if (s < NST - 1) begin : g_black
          assign pS[s+1][i] = pS[s][i] & pS[s][i-DIST];
        end
      end else begin : g_pass
        assign gS[s+1][i] = gS[s][i];
        if (s < NST - 1) begin : g_pp
          assign pS[s+1][i] = pS[s][i];
        end
      end
    end
  end

  // post-computation
  assign carry = {gS[NST][W-2:0], 1'b0};
  assign sum   = pS[0] ^ carry;
endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
(
  input  logic              inValid,
  input  logic              sampleNeg,
  input  logic              coefNeg,
  input  logic [COEF_W-1:0] coefMag,
  output csmCtrl_t          ctrl
);
  logic [PAIR_N-1:0] pairNz;
  logic [BYTE_N-1:0] nibNz;

  for (genvar k = 0; k < PAIR_N; k++) begin : g_pair
    assign pairNz[k] = |coefMag[4*k+3 -: 2];
  end
  for (genvar b = 0; b < BYTE_N; b++) begin : g_byte
    assign nibNz[b] = |coefMag[8*b+7 -: 4];
  end

  always_comb begin
    ctrl.load    = inValid;
    ctrl.negate  = sampleNeg ^ coefNeg;
    ctrl.pairAdd = pairNz;
    ctrl.nibAdd  = nibNz;
    ctrl.byteAdd = |coefMag[COEF_W-1:COEF_W/2];
  end
endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DATA_W-1:0]        sample,
  input  logic [COEF_W-1:0]        coef,
  input  csmCtrl_t                 ctrl,
  output logic                     sampleNeg,
  output logic                     coefNeg,
  output logic [COEF_W-1:0]        coefMag,
  output logic                     outValid,
  output logic [DATA_W+COEF_W-1:0] product
);
  localparam int PP_W   = DATA_W + 2;
  localparam int NIB_W  = DATA_W + 4;
  localparam int BYTE_W = DATA_W + 8;
  localparam int PROD_W = DATA_W + COEF_W;

  logic [DATA_W-1:0] sampleMag;
  logic [PP_W-1:0]   mult1, mult2, mult3;

  // sign conversion of operands
  assign sampleNeg = sample[DATA_W-1];
  assign coefNeg   = coef[COEF_W-1];
  assign sampleMag = sampleNeg ? (~sample + 1'b1) : sample;
  assign coefMag   = coefNeg ? (~coef + 1'b1) : coef;

  // partial product generator: the single shared adder forms 3x
  assign mult1 = {2'b00, sampleMag};
  assign mult2 = {1'b0, sampleMag, 1'b0};
  assign mult3 = mult1 + mult2;

  // one 4:1 selector per coefficient slice
  logic [SLICE_N-1:0][PP_W-1:0] pp;
  for (genvar i = 0; i < SLICE_N; i++) begin : g_sel
    logic [1:0] sel;
    assign sel   = coefMag[2*i+1 -: 2];
    assign pp[i] = (sel == 2'd0) ? '0 :
                   (sel == 2'd1) ? mult1 :
                   (sel == 2'd2) ? mult2 : mult3;
  end

  // layer 2: pair adders, bypassed when the upper slice is zero
  logic [PAIR_N-1:0][NIB_W-1:0] nibSum;
  for (genvar k = 0; k < PAIR_N; k++) begin : g_l2
    logic [NIB_W-1:0] lo, hi;
    assign lo        = NIB_W'(pp[2*k]);
    assign hi        = ctrl.pairAdd[k] ? {pp[2*k+1], 2'b00} : '0;
    assign nibSum[k] = ctrl.pairAdd[k] ? (lo + hi) : lo;
  end

  // layer 3: nibble adders, bypassed when the upper nibble is zero
  logic [BYTE_N-1:0][BYTE_W-1:0] byteSum;
  for (genvar b = 0; b < BYTE_N; b++) begin : g_l3
    logic [BYTE_W-1:0] lo, hi;
    assign lo         = BYTE_W'(nibSum[2*b]);
    assign hi         = ctrl.nibAdd[b] ? {nibSum[2*b+1], 4'b0000} : '0;
    assign byteSum[b] = ctrl.nibAdd[b] ? (lo + hi) : lo;
  end

  // final prefix adder, bypassed when the upper byte is zero
  logic [PROD_W-1:0] opLo, opHi, bkSum, magSum, prodNext;
  assign opLo = PROD_W'(byteSum[0]);
  assign opHi = ctrl.byteAdd ? {byteSum[1], 8'h00} : '0;

  csm_bk_adder #(.W(PROD_W)) u_bk (
    .opA (opLo),
    .opB (opHi),
    .sum (bkSum)
  );

  assign magSum   = ctrl.byteAdd ? bkSum : opLo;
  assign prodNext = ctrl.negate ? (~magSum + 1'b1) : magSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      product  <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) product <= prodNext;
    end
  end
endmodule

// File: rtl/csm_mult.sv
module csm_mult
  import csm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic signed [DATA_W-1:0]        sample,
  input  logic signed [COEF_W-1:0]        coef,
  output logic                            outValid,
  output logic signed [DATA_W+COEF_W-1:0] product
);
  csmCtrl_t          ctrl;
  logic              sampleNeg, coefNeg;
  logic [COEF_W-1:0] coefMag;

  csm_ctrl u_ctrl (
    .inValid   (inValid),
    .sampleNeg (sampleNeg),
    .coefNeg   (coefNeg),
    .coefMag   (coefMag),
    .ctrl      (ctrl)
  );

  csm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sample    (sample),
    .coef      (coef),
    .ctrl      (ctrl),
    .sampleNeg (sampleNeg),
    .coefNeg   (coefNeg),
    .coefMag   (coefMag),
    .outValid  (outValid),
    .product   (product)
  );
endmodule

// File: rtl/csm_mult_chk.sv
module csm_mult_chk
  import csm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            inValid,
  input logic signed [DATA_W-1:0]        sample,
  input logic signed [COEF_W-1:0]        coef,
  input logic                            outValid,
  input logic signed [DATA_W+COEF_W-1:0] product
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [PROD_W-1:0] sExt, cExt, refProd;
  assign sExt    = PROD_W'(sample);
  assign cExt    = PROD_W'(coef);
  assign refProd = sExt * cExt;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);  // R2
  AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (product == $past(refProd)));  // R3
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(product));  // R4
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (sample == '0 || coef == '0)) |=> (product == '0));  // R7
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sample != '0 && coef != '0) |=>
      (product[PROD_W-1] == $past(sample[DATA_W-1] ^ coef[COEF_W-1])));  // R9
endmodule

bind csm_mult csm_mult_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .sample   (sample),
  .coef     (coef),
  .outValid (outValid),
  .product  (product)
);

// File: tb/csm_mult_bench.sv
module csm_mult_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 6;
  localparam int PW = DW + 16;
  localparam int SMIN = -(1 << (DW - 1));
  localparam int SMAX = (1 << (DW - 1)) - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic signed [DW-1:0] sample = '0;
  logic signed [15:0]   coef = '0;
  logic                 outValid;
  logic signed [PW-1:0] product;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  csm_mult #(.DATA_W(DW)) u_csm_mult (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sample   (sample),
    .coef     (coef),
    .outValid (outValid),
    .product  (product)
  );

  // apply one operand pair at a falling edge, check one clock later
  task automatic runVec(input int s, input logic signed [15:0] c, input string tag);
    longint expv;
    sample  = DW'(s);
    coef    = c;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expv = longint'(s) * longint'(c);
    nChecks++;
    if (!outValid || longint'(product) != expv) begin
      nFails++;
      $display("FAIL %s: s=%0d c=%0d got valid=%0b product=%0d, expected valid=1 product=%0d",
               tag, s, c, outValid, longint'(product), expv);
    end
  endtask

  task automatic sweepSamples(input logic signed [15:0] c, input string tag);
    for (int s = SMIN; s <= SMAX; s++) runVec(s, c, tag);
  endtask

  initial begin
    logic [31:0] seed;
    logic signed [15:0] cv;
    longint held;
    repeat (3) @(negedge clk);
    // R1: reset state
    nChecks++;
    if (outValid !== 1'b0 || product !== '0) begin
      nFails++;
      $display("FAIL R1: got valid=%0b product=%0d, expected valid=0 product=0",
               outValid, longint'(product));
    end
    rstN = 1'b1;
    @(negedge clk);

    // R7 zero coefficient, R6 extremes (sweep includes sample zero and minimum)
    sweepSamples(16'sh0000, "R7");
    sweepSamples(16'sh8000, "R6");
    sweepSamples(16'sh7FFF, "R6");
    sweepSamples(16'sh0001, "R3");
    sweepSamples(-16'sh0001, "R9");
    sweepSamples(16'sh5555, "R3");
    sweepSamples(16'shAAAA, "R9");
    sweepSamples(16'sh3333, "R3");
    sweepSamples(16'shFFFE, "R9");

    // R5: every slice value in every slice position, and its negation
    for (int pos = 0; pos < 8; pos++) begin
      for (int v = 1; v < 4; v++) begin
        cv = 16'(v << (2 * pos));
        sweepSamples(cv, "R5");
        sweepSamples(16'(-cv), "R5");
      end
    end

    // R8: sparse coefficients that bypass pair, nibble or byte adders
    sweepSamples(16'sh0003, "R8");
    sweepSamples(16'sh0030, "R8");
    sweepSamples(16'sh00F0, "R8");
    sweepSamples(16'sh0F00, "R8");
    sweepSamples(16'sh3000, "R8");
    sweepSamples(16'sh0101, "R8");
    sweepSamples(16'sh0C03, "R8");
    sweepSamples(-16'sh00FF, "R8");

    // R4 and R2: hold while inValid is low
    runVec(5, 16'sh1234, "R3");
    held = longint'(product);
    for (int k = 0; k < 3; k++) begin
      inValid = 1'b0;
      sample  = DW'(-7 + k);
      coef    = 16'sh7777 - 16'(k);
      @(posedge clk);
      @(negedge clk);
      nChecks++;
      if (outValid !== 1'b0) begin
        nFails++;
        $display("FAIL R2: got valid=%0b, expected valid=0", outValid);
      end
      nChecks++;
      if (longint'(product) != held) begin
        nFails++;
        $display("FAIL R4: got product=%0d, expected product=%0d", longint'(product), held);
      end
    end
    runVec(SMIN, 16'sh8000, "R2");

    // R3 and R9: pseudo-random coefficients over all samples
    seed = 32'h1ACE_0B57;
    for (int n = 0; n < 700; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      sweepSamples(seed[23:8], "R3/R9");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got run still active, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule